// File: doc/BRIEF.md
# Radix-2² Delay-Feedback FFT Stage

This block is one stage of a streaming pipelined FFT over frames of N complex samples, where N is a power of four. It takes one complex sample per clock and returns one per clock. Each sample has separate two's-complement real and imaginary words. Two radix-2 butterflies in series make up the stage, and each has its own feedback delay line. The first butterfly pairs samples N/2 apart. The second pairs samples N/4 apart. Between the two, selected samples are rotated by -j. The rotation only swaps the real and imaginary words and negates one of them, so the stage does a full radix-4 step without a multiplier.

A frame begins with a sample marked by `in_start`. A single index counter, which `in_start` realigns, sequences the whole stage. Gaps in `in_valid` freeze the pipeline. The parameter `GROW` picks one of two ways to handle growth at each butterfly. With `GROW`=1 every butterfly adds one bit, so the output is W+2 bits and exact. With `GROW`=0 every butterfly halves its result with floor rounding, so the output stays W bits. Twiddle multiplication and output reordering belong to neighbouring blocks.

Top module: `r22_sdf_stage`

## Requirements
- R1: While `rst_n` is low and after it is released, `out_valid` is 0. `out_valid` is never 1 in a cycle unless the clock edge that began that cycle accepted an input sample.
- R2: A sample with `in_start`=1 and `in_valid`=1 has frame index 0. Later accepted samples take indices 1, 2, …, N-1 and then wrap. Samples that arrive with `in_valid`=1 before the first start are ignored: they change neither `out_valid` nor the output words.
- R3: After reset, the first `out_valid` appears on the clock edge that accepts frame index 3N/4 of the first frame, which is 3N/4+1 accepted samples in total.
- R4: Once outputs have begun, every accepted sample produces exactly one output with `out_valid`=1 on the same edge. A continuous input therefore gives a continuous output.
- R5: When `in_valid` is 0, the next cycle has `out_valid`=0 and the output words are unchanged.
- R6: The first butterfly forms y(m) = x(m)+x(m+N/2) for m < N/2 and y(m) = x(m-N/2)-x(m) for m ≥ N/2. The index m is the frame index.
- R7: Before the second butterfly, each y(m) with m ≥ N/2 and (m mod N/2) ≥ N/4 is rotated by -j: (re, im) becomes (im, -re).
- R8: Let z be the sequence after R7. Write each output index p as h + r, with h a multiple of N/2 and r < N/2. Output p is z(h+r)+z(h+r+N/4) if r < N/4, and z(h+r-N/4)-z(h+r) otherwise. Outputs leave in natural order p = 0..N-1, with frame f's output p on the edge that accepts overall sample f·N + 3N/4 + p.
- R9: With `GROW`=1 the outputs are W+2 bits and exactly equal to R6–R8, including frames made entirely of the most negative code.
- R10: With `GROW`=0 the outputs are W bits, and each butterfly result is floor(sum/2) or floor(difference/2). The -j negation of the most negative code does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| in_valid | input | 1 | Input sample present this cycle |
| in_start | input | 1 | Marks the sample with frame index 0 |
| in_re | input | W | Input real part, two's complement |
| in_im | input | W | Input imaginary part, two's complement |
| out_valid | output | 1 | Output sample present this cycle |
| out_re | output | W+2·GROW | Output real part, two's complement |
| out_im | output | W+2·GROW | Output imaginary part, two's complement |

## Verification
Suppose the index counter is misaligned or a butterfly mode bit is inverted. The first output then appears on the wrong edge, or its value is wrong, and this shows within the first 3N/4+1 accepted samples. A corrupted delay tap or a wrong rotation sign shows a different way. Outputs in particular index windows (quarter- or half-frame windows, depending on the fault) come out wrong, starting N/4 to N/2 samples after the fault. The bench places impulses so that each of these windows is hit. A pipeline that moves while `in_valid` is low is caught on the next idle cycle, because the held output words change.

// File: rtl/r22_pkg.sv
package r22_pkg;

  // Operating phase of one feedback butterfly
  typedef enum logic {
    PH_FILL    = 1'b0,   // pass delayed data out, load incoming sample
    PH_COMBINE = 1'b1    // add/subtract against the delayed sample
  } bf_phase_e;

  // Control word produced by the sequencer for one accepted sample
  typedef struct packed {
    logic      accept;
    bf_phase_e ph1;
    bf_phase_e ph2;
    logic      rot;
    logic      out_v;
  } seq_ctl_t;

endpackage

// File: rtl/r22_seq_ctrl.sv
module r22_seq_ctrl
  import r22_pkg::*;
#(
  parameter int N = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  input  logic     in_start,
  output seq_ctl_t ctl
);

  localparam int L = $clog2(N);
  localparam logic [L-1:0] IDX_ZERO = '0;

  logic [L-1:0] cnt_q, cnt_d, idx;
  logic         run_q, run_d;
  logic         primed_q, primed_d;
  logic         acc, late;

  // next-state and control decode
  always_comb begin
    idx      = in_start ? IDX_ZERO : cnt_q;
    acc      = in_valid & (in_start | run_q);
    late     = idx[L-1] & idx[L-2];
    cnt_d    = cnt_q;
    run_d    = run_q;
    primed_d = primed_q;
    if (acc) begin
      cnt_d = idx + L'(1);
      run_d = 1'b1;
      if (late) primed_d = 1'b1;
    end
    ctl.accept = acc;
    ctl.ph1    = idx[L-1] ? PH_COMBINE : PH_FILL;
    ctl.ph2    = idx[L-2] ? PH_COMBINE : PH_FILL;
    // recycled differences arrive while ph1 is FILL; rotate their n2=1 part
    ctl.rot    = ~idx[L-1] & idx[L-2];
    ctl.out_v  = acc & (primed_q | late);
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      run_q    <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      run_q    <= run_d;
      primed_q <= primed_d;
    end
  end

endmodule

// File: rtl/r22_fb_delay.sv
module r22_fb_delay #(
  parameter int DEPTH = 8,
  parameter int DW    = 9
) (
  input  logic          clk,
  input  logic          en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);

  logic [DW-1:0] tap_q [DEPTH];

  // datapath shift line, advanced only with the clock enable
  always_ff @(posedge clk) begin
    if (en) begin
      tap_q[0] <= din;
      for (int k = 1; k < DEPTH; k++) tap_q[k] <= tap_q[k-1];
    end
  end

  assign dout = tap_q[DEPTH-1];

endmodule

// File: rtl/r22_fb_butterfly.sv
module r22_fb_butterfly
  import r22_pkg::*;
#(
  parameter int IW    = 8,
  parameter int OW    = 9,
  parameter int DEPTH = 8,
  parameter bit GROW  = 1'b1
) (
  input  logic                 clk,
  input  logic                 en,
  input  bf_phase_e            phase,
  input  logic signed [IW-1:0] in_re,
  input  logic signed [IW-1:0] in_im,
  output logic signed [OW-1:0] out_re,
  output logic signed [OW-1:0] out_im
);

  localparam int AW = IW + 1;  // full-precision adder width

  logic signed [IW-1:0] x_c [2];
  logic signed [OW-1:0] y_c [2];

  assign x_c[0] = in_re;
  assign x_c[1] = in_im;
  assign out_re = y_c[0];
  assign out_im = y_c[1];

  for (genvar c = 0; c < 2; c++) begin : g_comp
    logic signed [OW-1:0] fb, wr, y;
    logic signed [AW-1:0] a, b, s, d, s_r, d_r;

    r22_fb_delay #(.DEPTH(DEPTH), .DW(OW)) i_dly (
      .clk  (clk),
      .en   (en),
      .din  (wr),
      .dout (fb)
    );

    always_comb begin
      a = AW'(fb);
      b = AW'(x_c[c]);
      s = a + b;
      d = a - b;
      if (GROW) begin
        s_r = s;
        d_r = d;
      end else begin
        s_r = s >>> 1;
        d_r = d >>> 1;
      end
      if (phase == PH_COMBINE) begin
        y  = OW'(s_r);
        wr = OW'(d_r);
      end else begin
        y  = fb;
        wr = OW'(b);
      end
    end

    assign y_c[c] = y;
  end

endmodule

// File: rtl/r22_sdf_stage.sv
module r22_sdf_stage
  import r22_pkg::*;
#(
  parameter int  N    = 16,
  parameter int  W    = 8,
  parameter bit  GROW = 1'b1,
  localparam int G    = GROW ? 1 : 0,
  localparam int OW   = W + 2 * G
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_start,
  input  logic signed [W-1:0]  in_re,
  input  logic signed [W-1:0]  in_im,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_re,
  output logic signed [OW-1:0] out_im
);

  localparam int W1  = W + G;   // first butterfly output width
  localparam int IW2 = W1 + 1;  // room for negating the most negative code

  seq_ctl_t ctl;

  r22_seq_ctrl #(.N(N)) i_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_start (in_start),
    .ctl      (ctl)
  );

  logic signed [W1-1:0] s1_re, s1_im;

  r22_fb_butterfly #(.IW(W), .OW(W1), .DEPTH(N/2), .GROW(GROW)) i_bf_a (
    .clk    (clk),
    .en     (ctl.accept),
    .phase  (ctl.ph1),
    .in_re  (in_re),
    .in_im  (in_im),
    .out_re (s1_re),
    .out_im (s1_im)
  );

  // -j rotation: swap the words and negate, in a widened word
  logic signed [IW2-1:0] e_re, e_im, r_re, r_im;

  always_comb begin
    e_re = IW2'(s1_re);
    e_im = IW2'(s1_im);
    if (ctl.rot) begin
      r_re = e_im;
      r_im = -e_re;
    end else begin
      r_re = e_re;
      r_im = e_im;
    end
  end

  logic signed [OW-1:0] s2_re, s2_im;

  r22_fb_butterfly #(.IW(IW2), .OW(OW), .DEPTH(N/4), .GROW(GROW)) i_bf_b (
    .clk    (clk),
    .en     (ctl.accept),
    .phase  (ctl.ph2),
    .in_re  (r_re),
    .in_im  (r_im),
    .out_re (s2_re),
    .out_im (s2_im)
  );

  // output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= ctl.out_v;
  end

  always_ff @(posedge clk) begin
    if (ctl.accept) begin
      out_re <= s2_re;
      out_im <= s2_im;
    end
  end

endmodule

// File: rtl/r22_sdf_stage_chk.sv
module r22_sdf_stage_chk #(
  parameter int N  = 16,
  parameter int OW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_start,
  input logic          out_valid,
  input logic [OW-1:0] out_re,
  input logic [OW-1:0] out_im
);

  localparam int PRIME = 3 * N / 4 + 1;
  localparam int CW    = $clog2(N + 1) + 1;

  logic          seen_start_q, seen_out_q;
  logic [CW-1:0] acc_q;
  logic          acc;

  assign acc = in_valid & (in_start | seen_start_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_start_q <= 1'b0;
      seen_out_q   <= 1'b0;
      acc_q        <= '0;
    end else begin
      if (acc) seen_start_q <= 1'b1;
      if (out_valid) seen_out_q <= 1'b1;
      if (acc && (acc_q < CW'(N))) acc_q <= acc_q + CW'(1);
    end
  end

  AST_VALID_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid)); // R1

  AST_IGNORED_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_start && !seen_start_q) |=> (!out_valid && $stable(out_re) && $stable(out_im))); // R2

  AST_PRIMED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (acc_q >= CW'(PRIME))); // R3

  AST_STREAM_CONTINUOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_out_q && acc) |=> out_valid); // R4

  AST_HOLD_ON_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_re) && $stable(out_im))); // R5

endmodule

bind r22_sdf_stage r22_sdf_stage_chk #(.N(N), .OW(OW)) i_r22_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_start  (in_start),
  .out_valid (out_valid),
  .out_re    (out_re),
  .out_im    (out_im)
);

// File: tb/test_r22_sdf_stage.sv
module test_r22_sdf_stage;

  localparam int N   = 16;
  localparam int W   = 8;
  localparam int NF  = 8;
  localparam int NS  = NF * N;
  localparam int OWG = W + 2;
  localparam int OWH = W;
  localparam int LAT = 3 * N / 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_start = 1'b0;
  logic signed [W-1:0] in_re = '0;
  logic signed [W-1:0] in_im = '0;
  logic ov_g, ov_h;
  logic signed [OWG-1:0] or_g, oi_g;
  logic signed [OWH-1:0] or_h, oi_h;

  always #2 clk = ~clk;  // 250 MHz

  r22_sdf_stage #(.N(N), .W(W), .GROW(1'b1)) i_r22_sdf_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
    .in_re(in_re), .in_im(in_im), .out_valid(ov_g), .out_re(or_g), .out_im(oi_g)
  );

  r22_sdf_stage #(.N(N), .W(W), .GROW(1'b0)) i_r22_sdf_stage_half (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
    .in_re(in_re), .in_im(in_im), .out_valid(ov_h), .out_re(or_h), .out_im(oi_h)
  );

  int xr[NS], xi[NS];
  int eg_r[NS], eg_i[NS], eh_r[NS], eh_i[NS];
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural two-butterfly model for one frame
  task automatic model(input int f, input bit grow);
    int y_r[N], y_i[N], z_r[N], z_i[N];
    int b, h, r, vr, vi;
    b = f * N;
    for (int m = 0; m < N; m++) begin
      if (m < N/2) begin
        vr = xr[b+m] + xr[b+m+N/2];
        vi = xi[b+m] + xi[b+m+N/2];
      end else begin
        vr = xr[b+m-N/2] - xr[b+m];
        vi = xi[b+m-N/2] - xi[b+m];
      end
      if (!grow) begin vr = vr >>> 1; vi = vi >>> 1; end
      y_r[m] = vr; y_i[m] = vi;
    end
    for (int m = 0; m < N; m++) begin
      if (m >= N/2 && (m % (N/2)) >= N/4) begin
        z_r[m] = y_i[m]; z_i[m] = -y_r[m];
      end else begin
        z_r[m] = y_r[m]; z_i[m] = y_i[m];
      end
    end
    for (int p = 0; p < N; p++) begin
      h = (p / (N/2)) * (N/2);
      r = p % (N/2);
      if (r < N/4) begin
        vr = z_r[h+r] + z_r[h+r+N/4];
        vi = z_i[h+r] + z_i[h+r+N/4];
      end else begin
        vr = z_r[h+r-N/4] - z_r[h+r];
        vi = z_i[h+r-N/4] - z_i[h+r];
      end
      if (!grow) begin vr = vr >>> 1; vi = vi >>> 1; end
      if (grow) begin eg_r[b+p] = vr; eg_i[b+p] = vi; end
      else begin eh_r[b+p] = vr; eh_i[b+p] = vi; end
    end
  endtask

  // bench-side view of accepted samples and idle cycles
  int acc_tb = 0;
  bit started = 1'b0;
  bit v_q = 1'b0;
  bit gap_q = 1'b0;

  always @(posedge clk) begin
    if (rst_n && in_valid && (in_start || started)) begin
      acc_tb  <= acc_tb + 1;
      started <= 1'b1;
    end
    v_q   <= rst_n && in_valid && (in_start || started);
    gap_q <= rst_n && !in_valid;
  end

  // output monitor, sampled away from the active edge
  int k = 0;
  bit seen = 1'b0;
  int last_g = 0;
  int last_h = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (gap_q && seen) begin
        check(ov_g == 1'b0, "R5 valid during idle", int'(ov_g), 0);
        check(int'(or_g) == last_g && int'(or_h) == last_h, "R5 held output word", int'(or_g), last_g);
      end
      if (v_q && seen) check(ov_g == 1'b1 && ov_h == 1'b1, "R4 one output per accepted input", int'(ov_g), 1);
      if (ov_g || ov_h) begin
        if (!seen) check(acc_tb == LAT + 1, "R3 first output position", acc_tb, LAT + 1);
        seen = 1'b1;
        if (k < NS) begin
          check(int'(or_g) == eg_r[k] && int'(oi_g) == eg_i[k],
                ((k / N) == 2) ? "R9 R6 R8 R7 exact real/imag" : "R9 R6 R8 exact real/imag",
                int'(or_g) * 4096 + int'(oi_g), eg_r[k] * 4096 + eg_i[k]);
          check(int'(or_h) == eh_r[k] && int'(oi_h) == eh_i[k],
                ((k / N) == 2) ? "R10 R6 R8 R7 halved real/imag" : "R10 R6 R8 halved real/imag",
                int'(or_h) * 4096 + int'(oi_h), eh_r[k] * 4096 + eh_i[k]);
        end
        k++;
        last_g = int'(or_g);
        last_h = int'(or_h);
      end
    end
  end

  // stimulus
  logic [15:0] lfsr;

  initial begin
    lfsr = 16'hACE1;
    for (int f = 0; f < NF; f++) begin
      for (int i = 0; i < N; i++) begin
        int n;
        n = f * N + i;
        case (f)
          0: begin xr[n] = i * 9 - 60; xi[n] = 30 - i * 4; end
          1: begin xr[n] = (i == 0) ? 100 : 0; xi[n] = (i == 0) ? -100 : 0; end
          2: begin xr[n] = (i == 13) ? 55 : 0; xi[n] = (i == 13) ? -77 : 0; end
          3: begin xr[n] = -128; xi[n] = -128; end
          4: begin xr[n] = (i % 2 == 0) ? 127 : -128; xi[n] = (i % 2 == 0) ? -128 : 127; end
          5, 6: begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            xr[n] = int'($signed(lfsr[7:0]));
            xi[n] = int'($signed(lfsr[15:8]));
          end
          default: begin xr[n] = 0; xi[n] = 0; end
        endcase
      end
      model(f, 1'b1);
      model(f, 1'b0);
    end

    repeat (3) @(negedge clk);
    check(ov_g == 1'b0 && ov_h == 1'b0, "R1 valid low in reset", int'(ov_g), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ov_g == 1'b0 && ov_h == 1'b0, "R1 valid low after reset", int'(ov_g), 0);

    // samples before any start must be ignored
    for (int j = 0; j < 5; j++) begin
      in_valid = 1'b1; in_start = 1'b0; in_re = 8'sd99; in_im = -8'sd99;
      @(negedge clk);
    end
    in_valid = 1'b0;
    check(ov_g == 1'b0 && ov_h == 1'b0, "R2 pre-start samples ignored", int'(ov_g), 0);
    @(negedge clk);

    for (int f = 0; f < NF; f++) begin
      for (int i = 0; i < N; i++) begin
        if (f == 6 && (i % 3) == 2) begin
          in_valid = 1'b0; in_start = 1'b0;
          @(negedge clk);
        end
        in_valid = 1'b1;
        in_start = (i == 0);
        in_re    = W'(xr[f*N+i]);
        in_im    = W'(xi[f*N+i]);
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    in_start = 1'b0;
    repeat (6) @(negedge clk);

    check(k == NS - LAT, "R4 output count", k, NS - LAT);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", k, NS - LAT);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule